// File: doc/BRIEF.md
# SDRAM Device-Side Burst Engine

This block models the memory side of a single-data-rate SDRAM at cycle level. It samples a command on every rising clock edge while clock enable is high. It keeps a small banked storage array and drives read and write column bursts through it. Commands cover mode loading, row activation, read, write, precharge and no-operation. Electrical timing, refresh and power-down are not modelled.

A controller loads the burst length, the burst ordering and the write policy into the mode register. It opens a row with an ACTIVE command and, after the row-to-column delay, issues READ and WRITE commands. A WRITE takes its first data word on the command edge. A READ drives its first word a fixed latency later. A per-beat mask drops single write words. In single-write mode every WRITE touches one column, while reads keep the full programmed burst. An access to a bank that is not ready is rejected and raises a one-cycle error flag.

The sequencer has three states: `ST_IDLE`, `ST_WR_BURST` and `ST_RD_BURST`. Its transitions:
- start-write: idle or any burst to `ST_WR_BURST`, on an accepted WRITE that needs more than one beat.
- start-read: idle or any burst to `ST_RD_BURST`, on an accepted READ with burst length above one.
- single-beat: an accepted access that needs only one beat goes to or stays in `ST_IDLE`.
- advance: a burst state stays put while beats remain.
- finish: a burst state goes to `ST_IDLE` after its last beat.
- cut: a burst state goes to `ST_IDLE` when a PRECHARGE closes the burst's bank.

Top module: `sdram_burst_dev`

## Requirements
- R1: The command is decoded from {cs_n, ras_n, cas_n, we_n} at a rising edge with cke high.
  - 0000 loads the mode register, 0011 is ACTIVE, 0101 is READ, 0100 is WRITE, 0010 is PRECHARGE and 0111 is NOP.
  - Any pattern with cs_n high is a NOP.
- R2: A mode load takes the burst-length code from addr[1:0] (0, 1, 2, 3 give 1, 2, 4, 8 beats), the ordering from addr[3] (0 sequential, 1 interleaved) and the write policy from addr[9] (0 full burst, 1 single column).
  - After reset the mode is one beat, sequential, full-burst writes.
- R3: In full-burst write mode, a WRITE to column c stores dq_in into the burst's columns on consecutive edges. Beat 0 is taken on the command edge.
- R4: A write beat sampled with dqm high leaves its column unchanged. The other beats of the burst are still stored.
- R5: With addr[9]=1 programmed, a WRITE stores only its command-edge word, whatever the burst length. Data presented on the following edges is not stored.
- R6: An accepted READ on edge T drives beat i onto dq_out, valid to be sampled at edge T+CAS+i. It uses the programmed length and ordering under either write policy.
- R7: Beat i of a burst of length n that starts at column c addresses base + offset. The base is c with its low log2(n) bits cleared.
  - Sequential ordering uses offset ((c mod n)+i) mod n.
  - Interleaved ordering uses offset (c mod n) XOR i.
- R8: dq_oe is high exactly while read data is driven. Otherwise dq_out is zero.
- R9: ACTIVE opens a bank on a row. An ACTIVE to an already open bank re-opens it on the new row and restarts the delay.
  - A READ or WRITE to that bank is accepted from TRCD edges after the ACTIVE.
  - An earlier access raises err and is dropped.
- R10: With addr[10] high on a READ or WRITE, the bank closes after the access's last beat. A following access to that bank then raises err until a new ACTIVE.
- R11: A READ or WRITE to a closed or not-yet-ready bank sets err for exactly one cycle, after the command edge. It writes nothing and drives no data.
- R12: An accepted READ or WRITE ends any burst in progress. The new access takes that edge's beat.
- R13: While cke is low the sampled command is treated as NOP and has no effect.
- R14: PRECHARGE with addr[10] high closes all banks. With addr[10] low it closes only bank ba. A burst on a closed bank stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge sampling |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable for command sampling |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Row, column and mode bits; bit 10 is auto-precharge / all-banks |
| dq_in | input | DATA_W | Write data |
| dqm | input | 1 | Write beat mask |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | Read data is being driven |
| err | output | 1 | One-cycle flag for a rejected access |

## Verification
Every combination of write policy, ordering and burst length is swept against each of the sixteen start columns. Each write is read back as a full burst. This separates wrapped from linear ordering and aligned from unaligned starts. It also shows whether single-write mode stops after one column while reads stay long. The masked beat moves across the burst positions, including positions past the burst end where it must have no effect. Directed sequences cover:
- an access one cycle before TRCD against one at exactly TRCD;
- auto-precharge on writes and reads;
- a burst cut short by a new command;
- commands issued with cke low or chip select high;
- single-bank against all-bank precharge.

// File: rtl/sdram_pkg.sv
package sdram_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_MRS,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_BURST,
        ST_RD_BURST
    } bst_e;

    // Command decode; clock enable low or chip select high both act as NOP
    function automatic cmd_e decode_cmd(input logic cke, input logic cs_n,
                                        input logic ras_n, input logic cas_n,
                                        input logic we_n);
        cmd_e c;
        c = CMD_NOP;
        if (cke && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  c = CMD_MRS;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    // Column of beat 'beat' in an aligned block of 2**blc columns
    function automatic logic [7:0] burst_col(input logic [7:0] start,
                                             input logic [2:0] beat,
                                             input logic [1:0] blc,
                                             input logic ilv);
        logic [7:0] msk;
        logic [7:0] off;
        msk = (8'd1 << blc) - 8'd1;
        if (ilv)
            off = (start & msk) ^ {5'd0, beat};
        else
            off = (start + {5'd0, beat}) & msk;
        return (start & ~msk) | (off & msk);
    endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] bl_in,
    input  logic       ilv_in,
    input  logic       single_in,
    output logic [1:0] bl_code,
    output logic       ilv,
    output logic       wr_single
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_code   <= 2'd0;
            ilv       <= 1'b0;
            wr_single <= 1'b0;
        end else if (load) begin
            bl_code   <= bl_in;
            ilv       <= ilv_in;
            wr_single <= single_in;
        end
    end

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track #(
    parameter int BA_W  = 2,
    parameter int ROW_W = 2,
    parameter int TRCD  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             pre,
    input  logic             pre_all,
    input  logic [BA_W-1:0]  ba,
    input  logic [ROW_W-1:0] row_in,
    input  logic             close_req,
    input  logic [BA_W-1:0]  close_ba,
    output logic             q_ready,
    output logic [ROW_W-1:0] q_row
);

    localparam int NB   = 1 << BA_W;
    localparam int CW   = $clog2(TRCD + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(TRCD - 1);

    logic             open_q [NB];
    logic [ROW_W-1:0] row_q  [NB];
    logic [CW-1:0]    cnt_q  [NB];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                open_q[i] <= 1'b0;
                row_q[i]  <= '0;
                cnt_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (act && ba == BA_W'(i)) begin
                    open_q[i] <= 1'b1;
                    row_q[i]  <= row_in;
                    cnt_q[i]  <= CNT_LOAD;
                end else begin
                    if ((pre && (pre_all || ba == BA_W'(i))) ||
                        (close_req && close_ba == BA_W'(i)))
                        open_q[i] <= 1'b0;
                    if (cnt_q[i] != '0)
                        cnt_q[i] <= cnt_q[i] - 1'b1;
                end
            end
        end
    end

    assign q_ready = open_q[ba] && (cnt_q[ba] == '0);
    assign q_row   = row_q[ba];

endmodule

// File: rtl/sdr_burst_fsm.sv
module sdr_burst_fsm
    import sdram_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 2,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             acc_ok,
    input  logic [BA_W-1:0]  ba,
    input  logic [COL_W-1:0] col,
    input  logic             a10,
    input  logic [ROW_W-1:0] row_in,
    input  logic [1:0]       bl_code,
    input  logic             ilv,
    input  logic             wr_single,
    output logic             acc_en,
    output logic             acc_we,
    output logic [BA_W-1:0]  acc_ba,
    output logic [ROW_W-1:0] acc_row,
    output logic [COL_W-1:0] acc_col,
    output logic             close_req,
    output logic [BA_W-1:0]  close_ba,
    output bst_e             state
);

    bst_e             state_q, state_d;
    logic [2:0]       cnt_q, cnt_d;
    logic [BA_W-1:0]  bank_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] start_q;
    logic             ap_q;

    logic new_rd, new_wr, new_acc, pre_hit, last_new, last_beat;
    logic [2:0] bl_last;

    assign bl_last   = 3'((4'd1 << bl_code) - 4'd1);
    assign new_rd    = (cmd == CMD_RD) && acc_ok;
    assign new_wr    = (cmd == CMD_WR) && acc_ok;
    assign new_acc   = new_rd || new_wr;
    assign pre_hit   = (cmd == CMD_PRE) && (state_q != ST_IDLE) &&
                       (a10 || ba == bank_q);
    assign last_new  = new_wr ? (wr_single || bl_code == 2'd0)
                              : (bl_code == 2'd0);
    assign last_beat = (cnt_q == bl_last);
    assign state     = state_q;

    // State register and burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bank_q  <= '0;
            row_q   <= '0;
            start_q <= '0;
            ap_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (new_acc) begin
                bank_q  <= ba;
                row_q   <= row_in;
                start_q <= col;
                ap_q    <= a10;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (new_acc) begin
            cnt_d = 3'd1;
            if (last_new)
                state_d = ST_IDLE;
            else if (new_wr)
                state_d = ST_WR_BURST;
            else
                state_d = ST_RD_BURST;
        end else if (pre_hit) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_WR_BURST, ST_RD_BURST: begin
                    if (last_beat)
                        state_d = ST_IDLE;
                    else
                        cnt_d = cnt_q + 3'd1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs: access strobe, address and close request
    always_comb begin
        acc_en    = 1'b0;
        acc_we    = 1'b0;
        acc_ba    = '0;
        acc_row   = '0;
        acc_col   = '0;
        close_req = 1'b0;
        close_ba  = '0;
        if (new_acc) begin
            acc_en    = 1'b1;
            acc_we    = new_wr;
            acc_ba    = ba;
            acc_row   = row_in;
            acc_col   = col;
            close_req = a10 && last_new;
            close_ba  = ba;
        end else if (!pre_hit) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_WR_BURST, ST_RD_BURST: begin
                    acc_en    = 1'b1;
                    acc_we    = (state_q == ST_WR_BURST);
                    acc_ba    = bank_q;
                    acc_row   = row_q;
                    acc_col   = COL_W'(burst_col(8'(start_q), cnt_q,
                                                 bl_code, ilv));
                    close_req = ap_q && last_beat;
                    close_ba  = bank_q;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdr_store.sv
module sdr_store #(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 2,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    parameter int CAS    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic              acc_mask,
    input  logic [BA_W-1:0]   acc_ba,
    input  logic [ROW_W-1:0]  acc_row,
    input  logic [COL_W-1:0]  acc_col,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int AW    = BA_W + ROW_W + COL_W;
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     idx;
    logic [CAS-1:0]    v_q;
    logic [DATA_W-1:0] d_q [CAS];

    assign idx = {acc_ba, acc_row, acc_col};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (acc_en && acc_we && !acc_mask) begin
            mem[idx] <= wdata;
        end
    end

    // Read latency pipeline: stage 0 fetches on the access edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int k = 0; k < CAS; k++)
                d_q[k] <= '0;
        end else begin
            v_q[0] <= acc_en && !acc_we;
            d_q[0] <= (acc_en && !acc_we) ? mem[idx] : '0;
            for (int k = 1; k < CAS; k++) begin
                v_q[k] <= v_q[k-1];
                d_q[k] <= d_q[k-1];
            end
        end
    end

    assign rd_valid = v_q[CAS-1];
    assign rd_data  = d_q[CAS-1];

endmodule

// File: rtl/sdram_burst_dev.sv
module sdram_burst_dev
    import sdram_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 2,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 11,
    parameter int TRCD   = 2,
    parameter int CAS    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              dqm,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              err
);

    cmd_e             cmd;
    logic [1:0]       bl_code;
    logic             ilv;
    logic             wr_single;
    logic             q_ready;
    logic [ROW_W-1:0] q_row;
    logic             acc_en, acc_we, close_req;
    logic [BA_W-1:0]  acc_ba, close_ba;
    logic [ROW_W-1:0] acc_row;
    logic [COL_W-1:0] acc_col;
    logic             rd_valid;
    logic [DATA_W-1:0] rd_data;
    bst_e             fsm_state;
    logic             err_q;
    logic             unused_addr;

    assign cmd         = decode_cmd(cke, cs_n, ras_n, cas_n, we_n);
    assign unused_addr = ^addr;

    sdr_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd == CMD_MRS),
        .bl_in     (addr[1:0]),
        .ilv_in    (addr[3]),
        .single_in (addr[9]),
        .bl_code   (bl_code),
        .ilv       (ilv),
        .wr_single (wr_single)
    );

    sdr_bank_track #(.BA_W(BA_W), .ROW_W(ROW_W), .TRCD(TRCD)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (cmd == CMD_ACT),
        .pre       (cmd == CMD_PRE),
        .pre_all   (addr[10]),
        .ba        (ba),
        .row_in    (addr[ROW_W-1:0]),
        .close_req (close_req),
        .close_ba  (close_ba),
        .q_ready   (q_ready),
        .q_row     (q_row)
    );

    sdr_burst_fsm #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .acc_ok    (q_ready),
        .ba        (ba),
        .col       (addr[COL_W-1:0]),
        .a10       (addr[10]),
        .row_in    (q_row),
        .bl_code   (bl_code),
        .ilv       (ilv),
        .wr_single (wr_single),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_ba    (acc_ba),
        .acc_row   (acc_row),
        .acc_col   (acc_col),
        .close_req (close_req),
        .close_ba  (close_ba),
        .state     (fsm_state)
    );

    sdr_store #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
                .DATA_W(DATA_W), .CAS(CAS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_mask (dqm),
        .acc_ba   (acc_ba),
        .acc_row  (acc_row),
        .acc_col  (acc_col),
        .wdata    (dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= (cmd == CMD_RD || cmd == CMD_WR) && !q_ready;
    end

    assign err    = err_q;
    assign dq_oe  = rd_valid;
    assign dq_out = rd_valid ? rd_data : '0;

endmodule

// File: rtl/sdram_burst_dev_chk.sv
module sdram_burst_dev_chk
    import sdram_pkg::*;
#(
    parameter int CAS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       dq_oe,
    input logic       err,
    input logic       wr_single,
    input logic [1:0] state
);

    localparam int SAT = CAS + 7;
    localparam int SW  = $clog2(SAT + 1);

    logic          col_cmd, rd_cmd, wr_cmd;
    logic [SW-1:0] since_rd;

    assign col_cmd = cke && !cs_n && ras_n && !cas_n;
    assign rd_cmd  = col_cmd && we_n;
    assign wr_cmd  = col_cmd && !we_n;

    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rd <= SW'(SAT);
        else if (rd_cmd)
            since_rd <= '0;
        else if (since_rd != SW'(SAT))
            since_rd <= since_rd + 1'b1;
    end

    // R11: an error flag always follows a column command
    a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(col_cmd));

    // R13: nothing sampled with cke low can flag an error
    a_r13_cke_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> !err);

    // R6: read data appears no later than CAS edges after a READ
    a_r6_oe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (since_rd < SW'(CAS)));

    // R8: the bus is driven only inside a read burst window
    a_r8_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (since_rd < SW'(CAS + 7)));

    // R5: in single-write mode a WRITE never opens a write burst
    a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wr_single) |=> (state != ST_WR_BURST || err));

endmodule

bind sdram_burst_dev sdram_burst_dev_chk #(.CAS(CAS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dq_oe     (dq_oe),
    .err       (err),
    .wr_single (wr_single),
    .state     (fsm_state)
);

// File: tb/tb_sdram_burst_dev.sv
module tb_sdram_burst_dev;

    localparam int BA_W = 2, ROW_W = 2, COL_W = 4, DATA_W = 8;
    localparam int ADDR_W = 11, TRCD = 2, CAS = 2;

    localparam logic [3:0] C_NOP = 4'b0111, C_MRS = 4'b0000, C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010;
    localparam logic [3:0] C_DESEL_WR = 4'b1100;

    logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BA_W-1:0]   ba = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] dq_in = '0;
    logic dqm = 1'b0;
    logic [DATA_W-1:0] dq_out;
    logic dq_oe, err;

    int checks = 0, fails = 0;
    int cur_blc = 0, cur_ilv = 0, cur_wbm = 0;
    logic cke_next = 1'b1;
    logic [7:0] shadow [256];
    int open_row [4];

    sdram_burst_dev #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                      .ADDR_W(ADDR_W), .TRCD(TRCD), .CAS(CAS)) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dq_in(dq_in),
        .dqm(dqm), .dq_out(dq_out), .dq_oe(dq_oe), .err(err));

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int idx(input int b, input int r, input int c);
        return b * 64 + r * 16 + c;
    endfunction

    function automatic int col_of(input int s, input int i, input int blc, input int il);
        int n = 1 << blc;
        int base = s - (s % n);
        return il ? base + ((s % n) ^ i) : base + ((s + i) % n);
    endfunction

    task automatic drive(input logic [3:0] c, input int b, input int a,
                         input int d, input logic m);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        cke   = cke_next;
        ba    = BA_W'(b);
        addr  = ADDR_W'(a);
        dq_in = DATA_W'(d);
        dqm   = m;
    endtask

    task automatic nop();
        drive(C_NOP, 0, 0, 0, 1'b0);
    endtask

    task automatic set_mode(input int blc, input int il, input int wbm);
        drive(C_MRS, 0, blc | (il << 3) | (wbm << 9), 0, 1'b0);
        cur_blc = blc; cur_ilv = il; cur_wbm = wbm;
    endtask

    task automatic activate(input int b, input int r);
        drive(C_ACT, b, r, 0, 1'b0);
        open_row[b] = r;
        repeat (TRCD - 1) nop();
    endtask

    // Drives up to 'cnt' beats of a write burst and updates the shadow copy
    task automatic write_burst(input int b, input int c, input int ap,
                               input int seed, input logic [7:0] mask, input int cnt);
        int n = 1 << cur_blc;
        int nd = (cnt < n) ? cnt : n;
        int nw = cur_wbm ? 1 : n;
        for (int i = 0; i < nd; i++) begin
            drive(i == 0 ? C_WR : C_NOP, b, i == 0 ? (c | (ap << 10)) : 0,
                  (seed + i * 17) & 255, mask[i]);
            if (i == 1) chk("R9 write accepted at TRCD", 32'(err), 0);
            if (i < nw && !mask[i])
                shadow[idx(b, open_row[b], col_of(c, i, cur_blc, cur_ilv))] = 8'((seed + i * 17) & 255);
        end
    endtask

    task automatic read_check(input int b, input int c, input int ap, input string req);
        int n = 1 << cur_blc;
        drive(C_RD, b, c | (ap << 10), 0, 1'b0);
        for (int j = 1; j <= CAS + n; j++) begin
            nop();
            if (j < CAS) chk({req, " R6 no data before latency"}, 32'(dq_oe), 0);
            else if (j < CAS + n) begin
                chk({req, " R6 oe during burst"}, 32'(dq_oe), 1);
                chk({req, " R7 data"}, 32'(dq_out),
                    32'(shadow[idx(b, open_row[b], col_of(c, j - CAS, cur_blc, cur_ilv))]));
            end else begin
                chk({req, " R8 oe off after burst"}, 32'(dq_oe), 0);
                chk({req, " R8 bus zero"}, 32'(dq_out), 0);
            end
        end
    endtask

    task automatic expect_err(input int b, input int c, input string req);
        drive(C_RD, b, c, 0, 1'b0);
        nop();
        chk({req, " R11 err raised"}, 32'(err), 1);
        nop();
        chk({req, " R11 err one cycle"}, 32'(err), 0);
        for (int j = 0; j < CAS + 1; j++) begin
            chk({req, " R11 no read data"}, 32'(dq_oe), 0);
            nop();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 8'd0;
        for (int i = 0; i < 4; i++) open_row[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 reset oe", 32'(dq_oe), 0);
        chk("R8 reset bus", 32'(dq_out), 0);
        chk("R11 reset err", 32'(err), 0);

        // R11: bank never activated
        expect_err(2, 0, "R11");

        // R2: reset mode is one beat; NOP beats must not be stored
        activate(0, 0);
        write_burst(0, 5, 0, 8'hA0, 8'h00, 8);
        repeat (3) drive(C_NOP, 0, 0, 8'hEE, 1'b0);
        set_mode(2, 0, 0);
        read_check(0, 4, 0, "R2");

        // R3 R4 R5 R7: sweep of policy, ordering, length and start column
        for (int wbm = 0; wbm < 2; wbm++)
            for (int il = 0; il < 2; il++)
                for (int blc = 0; blc < 4; blc++)
                    for (int s = 0; s < 16; s++) begin
                        set_mode(blc, il, wbm);
                        activate(s % 4, (s / 4) % 4);
                        write_burst(s % 4, s, 0, s * 16 + blc * 5 + wbm * 7 + il,
                                    8'(1 << ((s + blc) % 8)), 8);
                        read_check(s % 4, s, 0, wbm ? "R5 R4" : "R3 R4");
                    end

        // R9: too early is rejected, data unchanged
        set_mode(2, 0, 0);
        drive(C_ACT, 1, 2, 0, 1'b0);
        open_row[1] = 2;
        drive(C_WR, 1, 0, 8'h55, 1'b0);
        nop();
        chk("R9 early write err", 32'(err), 1);
        nop();
        read_check(1, 0, 0, "R9");

        // R10: auto precharge on write and read
        set_mode(2, 1, 0);
        activate(2, 1);
        write_burst(2, 6, 1, 8'h30, 8'h04, 8);
        expect_err(2, 6, "R10 after write");
        activate(2, 1);
        read_check(2, 4, 1, "R10");
        expect_err(2, 4, "R10 after read");

        // R12: a new write cuts a BL8 write after three beats
        set_mode(3, 0, 0);
        activate(3, 0);
        write_burst(3, 0, 0, 8'h10, 8'h00, 3);
        write_burst(3, 8, 0, 8'h60, 8'h00, 8);
        read_check(3, 0, 0, "R12");
        read_check(3, 8, 0, "R12");

        // R13: commands with cke low have no effect
        set_mode(2, 0, 0);
        activate(0, 3);
        cke_next = 1'b0;
        drive(C_WR, 0, 0, 8'h77, 1'b0);
        cke_next = 1'b1;
        repeat (4) drive(C_NOP, 0, 0, 8'h77, 1'b0);
        read_check(0, 0, 0, "R13");
        drive(C_PRE, 0, 1 << 10, 0, 1'b0);
        cke_next = 1'b0;
        drive(C_ACT, 0, 3, 0, 1'b0);
        cke_next = 1'b1;
        nop();
        expect_err(0, 0, "R13");

        // R14: single-bank vs all-bank precharge
        activate(0, 0);
        activate(1, 0);
        drive(C_PRE, 0, 0, 0, 1'b0);
        read_check(1, 0, 0, "R14");
        expect_err(0, 0, "R14");
        drive(C_PRE, 0, 1 << 10, 0, 1'b0);
        expect_err(1, 0, "R14");

        // R1: chip select high turns a write pattern into NOP
        activate(3, 2);
        drive(C_DESEL_WR, 3, 0, 8'h99, 1'b0);
        repeat (4) drive(C_NOP, 0, 0, 8'h99, 1'b0);
        read_check(3, 0, 0, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule